// File: doc/BRIEF.md
# Power Mode Sequencer for Clock Sources

This block is the hardware state machine that moves a chip between four power modes: full speed, crystal speed, crawl and sleep. In each mode it drives the core and bus clock multiplexer selects, the enable and bypass controls of a main PLL, the enable of a second PLL, and the clock-gating enables for the core, the bus and a group of peripherals. The analog PLLs are outside the block. Only their enable and lock signals reach it.

Software writes a target mode through a one-cycle request strobe. The sequencer then walks a fixed series of steps. It first powers any PLL the target needs and waits for that PLL's lock flag. It then gates the core and bus clocks for one cycle, moves the multiplexers while the clocks are gated, and re-opens the clocks in the new mode. A status field reports the settled mode and a busy flag covers the whole walk.

In sleep the logic acts only on cycles marked by a 32 kHz tick. A wake interrupt in the crawl or sleep mode acts as a request for full speed. The mode options are the 32 kHz core clock in crawl, powering off the main PLL in the crystal and crawl modes, and keeping the second PLL in sleep. These options are captured when a transition starts and take effect with that transition.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the block is in SLOW (mode_status=1) with busy=0. Outputs: core_sel=1, bus_sel=1, pll1_bypass=1, pll1_en=1, pll2_en=1, core_clk_en=1, bus_clk_en=1, periph_clk_en=~periph_gate. Mode options read as 0.
- R2: Mode codes on req_mode and mode_status are NORMAL=0, SLOW=1, DOZE=2, SLEEP=3, with mode_status[2]=0. Settled NORMAL gives core_sel=0 (PLL), bus_sel=0 (PLL), pll1_bypass=0, pll1_en=1, pll2_en=1, core and bus enables high, and periph_clk_en=~periph_gate.
- R3: Settled SLOW gives core_sel=1 (crystal), bus_sel=1 (crystal), pll1_bypass=1, pll2_en=1, pll1_en equal to NOT the captured pll1_off_lowspd option, core and bus enables high, and periph_clk_en=~periph_gate.
- R4: Settled DOZE matches SLOW, except that core_sel=2 (32 kHz) when the captured doze_core_32k option is 1, and core_sel=1 when it is 0.
- R5: Settled SLEEP gives pll1_en=0, pll2_en equal to the captured pll2_keep_sleep option, core_sel=2, bus_sel=1, pll1_bypass=1, and core_clk_en, bus_clk_en and periph_clk_en all 0.
- R6: When the target is NORMAL, pll1_en is 1 throughout the transition, and pll1_bypass and the selects stay at their old values until pll1_lock has been seen high. A target other than SLEEP also waits for pll2_lock. busy stays 1 while the block waits.
- R7: core_sel, bus_sel and pll1_bypass change only in a cycle in which core_clk_en and bus_clk_en are 0 and were also 0 in the previous cycle.
- R8: With the needed locks high, a request sampled at edge e0 makes busy 1 after edges e1, e2 and e3. After edge e4, busy is 0 and mode_status shows the new mode. mode_status changes only as busy falls.
- R9: A request for the mode already in force is ignored. busy stays 0 and every output keeps its value.
- R10: A request that arrives while busy is held. When the current transition ends, the held request starts one edge later, and a later request overwrites an earlier held one.
- R11: In settled SLEEP, a held request starts only at an edge where tick_32k is 1.
- R12: wake_irq in a settled DOZE or SLEEP, with no request strobe in the same cycle, acts as a request for NORMAL. In NORMAL or SLOW it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested mode code |
| doze_core_32k | input | 1 | Option: core runs on 32 kHz in DOZE |
| pll1_off_lowspd | input | 1 | Option: main PLL powered off in SLOW and DOZE |
| pll2_keep_sleep | input | 1 | Option: second PLL kept running in SLEEP |
| periph_gate | input | NP | Per-peripheral gate request (1 = clock off) |
| pll1_lock | input | 1 | Main PLL lock flag |
| pll2_lock | input | 1 | Second PLL lock flag |
| wake_irq | input | 1 | Wake interrupt |
| tick_32k | input | 1 | One-cycle mark of the 32 kHz clock |
| core_sel | output | 2 | Core clock select: 0 PLL, 1 crystal, 2 32 kHz |
| bus_sel | output | 1 | Bus clock select: 0 PLL, 1 crystal |
| pll1_en | output | 1 | Main PLL enable |
| pll1_bypass | output | 1 | Main PLL bypass onto the crystal |
| pll2_en | output | 1 | Second PLL enable |
| core_clk_en | output | 1 | Core clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| periph_clk_en | output | NP | Peripheral kernel clock enables |
| mode_status | output | 3 | Settled mode code |
| busy | output | 1 | Transition in progress |

## Verification
Every result is due a fixed number of edges after its stimulus. When the locks are already high, busy rises one edge after the request edge, the clocks are gated after the second edge, the selects move after the third, and the new status appears after the fourth. A lock that rises late adds its own delay and is then followed by three edges. In sleep the start waits for the tick edge. Inputs are driven on falling edges and outputs are read on falling edges, counted from the edge that sampled the stimulus. Each check therefore falls in exactly one of these cycles. The bench also sweeps every pair of source and target modes with varied options.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLOW   = 2'd1,
        MODE_DOZE   = 2'd2,
        MODE_SLEEP  = 2'd3
    } pmode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOCK   = 2'd1,
        PH_GATE   = 2'd2,
        PH_SWITCH = 2'd3
    } phase_e;

    localparam logic [1:0] CSRC_PLL  = 2'd0;
    localparam logic [1:0] CSRC_XTAL = 2'd1;
    localparam logic [1:0] CSRC_32K  = 2'd2;

    typedef struct packed {
        logic d32;
        logic p1off;
        logic p2keep;
    } modeopt_t;

    typedef struct packed {
        logic [1:0] core_sel;
        logic       bus_sel;
        logic       pll1_bypass;
        logic       pll1_en;
        logic       pll2_en;
        logic       core_en;
        logic       bus_en;
        logic       periph_on;
    } clkcfg_t;

    function automatic logic needs_pll1(pmode_e m);
        return m == MODE_NORMAL;
    endfunction

    function automatic logic needs_pll2(pmode_e m);
        return m != MODE_SLEEP;
    endfunction

    function automatic clkcfg_t mode_cfg(pmode_e m, modeopt_t o);
        clkcfg_t c;
        c = '0;
        case (m)
            MODE_NORMAL: begin
                c.core_sel = CSRC_PLL;  c.bus_sel = 1'b0; c.pll1_bypass = 1'b0;
                c.pll1_en  = 1'b1;      c.pll2_en = 1'b1;
                c.core_en  = 1'b1;      c.bus_en  = 1'b1; c.periph_on = 1'b1;
            end
            MODE_SLOW: begin
                c.core_sel = CSRC_XTAL; c.bus_sel = 1'b1; c.pll1_bypass = 1'b1;
                c.pll1_en  = ~o.p1off;  c.pll2_en = 1'b1;
                c.core_en  = 1'b1;      c.bus_en  = 1'b1; c.periph_on = 1'b1;
            end
            MODE_DOZE: begin
                c.core_sel = o.d32 ? CSRC_32K : CSRC_XTAL;
                c.bus_sel  = 1'b1;      c.pll1_bypass = 1'b1;
                c.pll1_en  = ~o.p1off;  c.pll2_en = 1'b1;
                c.core_en  = 1'b1;      c.bus_en  = 1'b1; c.periph_on = 1'b1;
            end
            default: begin
                c.core_sel = CSRC_32K;  c.bus_sel = 1'b1; c.pll1_bypass = 1'b1;
                c.pll1_en  = 1'b0;      c.pll2_en = o.p2keep;
                c.core_en  = 1'b0;      c.bus_en  = 1'b0; c.periph_on = 1'b0;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pmc_req_hold.sv
module pmc_req_hold
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  pmode_e req_mode,
    input  logic   wake_irq,
    input  logic   idle,
    input  pmode_e cur_mode,
    input  logic   take,
    output logic   pend_vld,
    output pmode_e pend_mode
);
    logic wake_req;

    assign wake_req = wake_irq && idle &&
                      (cur_mode == MODE_DOZE || cur_mode == MODE_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_mode <= MODE_NORMAL;
        end else if (req_valid) begin
            pend_vld  <= 1'b1;
            pend_mode <= req_mode;
        end else if (wake_req) begin
            pend_vld  <= 1'b1;
            pend_mode <= MODE_NORMAL;
        end else if (take) begin
            pend_vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
    import pmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pend_vld,
    input  pmode_e   pend_mode,
    input  logic     pll1_lock,
    input  logic     pll2_lock,
    input  logic     tick_32k,
    input  modeopt_t opt_in,
    output logic     take,
    output phase_e   phase,
    output pmode_e   cur_mode,
    output pmode_e   tgt_mode,
    output modeopt_t opt_cur,
    output modeopt_t opt_tgt
);
    logic start_ok;
    logic locks_ok;

    assign start_ok = (cur_mode != MODE_SLEEP) || tick_32k;
    assign take     = (phase == PH_IDLE) && pend_vld && start_ok;
    assign locks_ok = (!needs_pll1(tgt_mode) || pll1_lock) &&
                      (!needs_pll2(tgt_mode) || pll2_lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cur_mode <= MODE_SLOW;
            tgt_mode <= MODE_SLOW;
            opt_cur  <= '0;
            opt_tgt  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (take && pend_mode != cur_mode) begin
                        phase    <= PH_LOCK;
                        tgt_mode <= pend_mode;
                        opt_tgt  <= opt_in;
                    end
                end
                PH_LOCK: begin
                    if (locks_ok) phase <= PH_GATE;
                end
                PH_GATE: begin
                    phase <= PH_SWITCH;
                end
                default: begin
                    phase    <= PH_IDLE;
                    cur_mode <= tgt_mode;
                    opt_cur  <= opt_tgt;
                end
            endcase
        end
    end
endmodule

// File: rtl/pmc_clk_out.sv
module pmc_clk_out
    import pmc_pkg::*;
#(
    parameter int NP = 4
) (
    input  phase_e         phase,
    input  pmode_e         cur_mode,
    input  pmode_e         tgt_mode,
    input  modeopt_t       opt_cur,
    input  modeopt_t       opt_tgt,
    input  logic [NP-1:0]  periph_gate,
    output clkcfg_t        cfg,
    output logic [NP-1:0]  periph_en
);
    clkcfg_t c_cur;
    clkcfg_t c_tgt;

    assign c_cur = mode_cfg(cur_mode, opt_cur);
    assign c_tgt = mode_cfg(tgt_mode, opt_tgt);

    always_comb begin
        cfg = c_cur;
        if (phase != PH_IDLE) begin
            cfg.pll1_en = c_cur.pll1_en | c_tgt.pll1_en;
            cfg.pll2_en = c_cur.pll2_en | c_tgt.pll2_en;
        end
        if (phase == PH_GATE || phase == PH_SWITCH) begin
            cfg.core_en = 1'b0;
            cfg.bus_en  = 1'b0;
        end
        if (phase == PH_SWITCH) begin
            cfg.core_sel    = c_tgt.core_sel;
            cfg.bus_sel     = c_tgt.bus_sel;
            cfg.pll1_bypass = c_tgt.pll1_bypass;
        end
    end

    assign periph_en = cfg.periph_on ? ~periph_gate : '0;
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pmc_pkg::*;
#(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic          doze_core_32k,
    input  logic          pll1_off_lowspd,
    input  logic          pll2_keep_sleep,
    input  logic [NP-1:0] periph_gate,
    input  logic          pll1_lock,
    input  logic          pll2_lock,
    input  logic          wake_irq,
    input  logic          tick_32k,
    output logic [1:0]    core_sel,
    output logic          bus_sel,
    output logic          pll1_en,
    output logic          pll1_bypass,
    output logic          pll2_en,
    output logic          core_clk_en,
    output logic          bus_clk_en,
    output logic [NP-1:0] periph_clk_en,
    output logic [2:0]    mode_status,
    output logic          busy
);
    logic     take, pend_vld;
    pmode_e   pend_mode, cur_mode, tgt_mode;
    phase_e   phase;
    modeopt_t opt_in, opt_cur, opt_tgt;
    clkcfg_t  cfg;

    assign opt_in = '{d32: doze_core_32k, p1off: pll1_off_lowspd, p2keep: pll2_keep_sleep};

    pmc_req_hold u_hold (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(pmode_e'(req_mode)),
        .wake_irq(wake_irq), .idle(phase == PH_IDLE), .cur_mode(cur_mode),
        .take(take), .pend_vld(pend_vld), .pend_mode(pend_mode)
    );

    pmc_seq u_seq (
        .clk(clk), .rst(rst), .pend_vld(pend_vld), .pend_mode(pend_mode),
        .pll1_lock(pll1_lock), .pll2_lock(pll2_lock), .tick_32k(tick_32k),
        .opt_in(opt_in), .take(take), .phase(phase), .cur_mode(cur_mode),
        .tgt_mode(tgt_mode), .opt_cur(opt_cur), .opt_tgt(opt_tgt)
    );

    pmc_clk_out #(.NP(NP)) u_out (
        .phase(phase), .cur_mode(cur_mode), .tgt_mode(tgt_mode),
        .opt_cur(opt_cur), .opt_tgt(opt_tgt), .periph_gate(periph_gate),
        .cfg(cfg), .periph_en(periph_clk_en)
    );

    assign core_sel    = cfg.core_sel;
    assign bus_sel     = cfg.bus_sel;
    assign pll1_en     = cfg.pll1_en;
    assign pll1_bypass = cfg.pll1_bypass;
    assign pll2_en     = cfg.pll2_en;
    assign core_clk_en = cfg.core_en;
    assign bus_clk_en  = cfg.bus_en;
    assign mode_status = {1'b0, cur_mode};
    assign busy        = (phase != PH_IDLE);
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] core_sel,
    input logic       bus_sel,
    input logic       pll1_bypass,
    input logic       pll1_en,
    input logic       pll1_lock,
    input logic       core_clk_en,
    input logic       bus_clk_en,
    input logic [2:0] mode_status,
    input logic       busy
);
    a_r7_sel_moves_gated: assert property (@(posedge clk) disable iff (rst)
        (!$stable(core_sel) || !$stable(bus_sel) || !$stable(pll1_bypass)) |->
        (!core_clk_en && !bus_clk_en && !$past(core_clk_en) && !$past(bus_clk_en)));

    a_r6_bypass_after_lock: assert property (@(posedge clk) disable iff (rst)
        $fell(pll1_bypass) |-> ($past(pll1_lock, 2) && pll1_en));

    a_r8_status_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_status) |-> ($past(busy) && !busy));

    a_r5_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode_status == 3'd3 && !busy) |-> (!pll1_en && !core_clk_en && !bus_clk_en));

    a_r2_status_code: assert property (@(posedge clk) disable iff (rst)
        mode_status[2] == 1'b0);
endmodule

bind pwr_mode_ctl pmc_chk u_chk (
    .clk(clk), .rst(rst), .core_sel(core_sel), .bus_sel(bus_sel),
    .pll1_bypass(pll1_bypass), .pll1_en(pll1_en), .pll1_lock(pll1_lock),
    .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .mode_status(mode_status), .busy(busy)
);

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
    localparam int NP = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, doze_core_32k = 0, pll1_off_lowspd = 0, pll2_keep_sleep = 0;
    logic [1:0] req_mode = 0;
    logic [NP-1:0] periph_gate = 0;
    logic pll1_lock = 1, pll2_lock = 1, wake_irq = 0, tick_32k = 1;
    logic [1:0] core_sel;
    logic bus_sel, pll1_en, pll1_bypass, pll2_en, core_clk_en, bus_clk_en, busy;
    logic [NP-1:0] periph_clk_en;
    logic [2:0] mode_status;

    int total = 0, bad = 0, cyc = 0;
    int cur_m = 1;
    logic [2:0] opt_s = 3'b000;   // {d32, p1off, p2keep} captured at last transition

    always #5 clk = ~clk;

    pwr_mode_ctl #(.NP(NP)) u0 (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_out(int m, logic [2:0] o, logic [NP-1:0] g);
        logic [1:0] cs; logic bs, byp, p1, p2, ce, be; logic [NP-1:0] pe;
        pe = ~g;
        case (m)
            0: begin cs = 0; bs = 0; byp = 0; p1 = 1; p2 = 1; ce = 1; be = 1; end
            1: begin cs = 1; bs = 1; byp = 1; p1 = ~o[1]; p2 = 1; ce = 1; be = 1; end
            2: begin cs = o[2] ? 2'd2 : 2'd1; bs = 1; byp = 1; p1 = ~o[1]; p2 = 1; ce = 1; be = 1; end
            default: begin cs = 2; bs = 1; byp = 1; p1 = 0; p2 = o[0]; ce = 0; be = 0; pe = '0; end
        endcase
        return {cs, bs, byp, p1, p2, ce, be, pe};
    endfunction

    function automatic logic [15:0] act_out();
        return {core_sel, bus_sel, pll1_bypass, pll1_en, pll2_en, core_clk_en, bus_clk_en, periph_clk_en};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(int m);
        req_valid = 1; req_mode = 2'(m);
        @(negedge clk);
        req_valid = 0;
    endtask

    // full transition with locks high; checks timing (R8), gating (R7) and settled outputs
    task automatic go(int m, string tag);
        logic [2:0] o;
        o = {doze_core_32k, pll1_off_lowspd, pll2_keep_sleep};
        req(m);
        if (m == cur_m) begin
            for (int i = 0; i < 4; i++) begin
                chk({tag, " R9 busy"}, 16'(busy), 0);
                chk({tag, " R9 outputs"}, act_out(), exp_out(cur_m, opt_s, periph_gate));
                step(1);
            end
        end else begin
            step(1);
            chk({tag, " R8 busy e1"}, 16'(busy), 1);
            chk({tag, " R8 status held"}, 16'(mode_status), 16'(cur_m));
            step(1);
            chk({tag, " R7 gated"}, 16'({core_clk_en, bus_clk_en}), 0);
            step(1);
            chk({tag, " R7 sel moved while gated"},
                16'({core_clk_en, core_sel, bus_sel, pll1_bypass}),
                16'({1'b0, exp_out(m, o, periph_gate)[11:10], exp_out(m, o, periph_gate)[9:8]}));
            chk({tag, " R8 busy e3"}, 16'(busy), 1);
            step(1);
            cur_m = m; opt_s = o;
            chk({tag, " R8 busy done"}, 16'(busy), 0);
            chk({tag, " R8 status new"}, 16'(mode_status), 16'(m));
            chk({tag, " R2/R3/R4/R5 outputs"}, act_out(), exp_out(m, opt_s, periph_gate));
        end
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        chk("R1 reset status", 16'({busy, mode_status}), 16'd1);
        chk("R1 reset outputs", act_out(), exp_out(1, 3'b000, periph_gate));

        // sweep all source/target pairs with varied options
        for (int i = 0; i < 16; i++) begin
            int f = i / 4;
            int t = i % 4;
            periph_gate = 4'(i * 5);
            {doze_core_32k, pll1_off_lowspd, pll2_keep_sleep} = 3'(i);
            go(f, "sweep src");
            {doze_core_32k, pll1_off_lowspd, pll2_keep_sleep} = 3'(7 - (i % 8));
            go(t, "sweep dst");
        end

        // R6: late PLL lock holds the transition
        go(1, "R6 setup");
        pll1_lock = 0;
        req(0);
        step(6);
        chk("R6 waiting", 16'({busy, pll1_en, pll1_bypass, core_sel}), 16'({3'b111, 2'd1}));
        pll1_lock = 1;
        step(2);
        chk("R6 busy after lock", 16'(busy), 1);
        step(1);
        chk("R6 done", 16'({busy, mode_status}), 16'd0);
        cur_m = 0;
        chk("R6 outputs", act_out(), exp_out(0, opt_s, periph_gate));

        // R10: request while busy is held, run afterwards
        req(1);
        req(2);
        step(3);
        chk("R10 first done", 16'({busy, mode_status}), 16'd1);
        step(1);
        chk("R10 held starts", 16'(busy), 1);
        step(3);
        chk("R10 second done", 16'({busy, mode_status}), 16'd2);
        cur_m = 2;
        opt_s = {doze_core_32k, pll1_off_lowspd, pll2_keep_sleep};

        // R12: wake in DOZE goes to NORMAL
        wake_irq = 1; step(1); wake_irq = 0;
        step(4);
        chk("R12 wake from DOZE", 16'({busy, mode_status}), 16'd0);
        cur_m = 0;
        wake_irq = 1; step(1); wake_irq = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R12 wake ignored in NORMAL", 16'({busy, mode_status}), 16'd0);
            step(1);
        end

        // R11: sleep waits for tick
        go(3, "R11 setup");
        tick_32k = 0;
        req(0);
        step(5);
        chk("R11 no tick no start", 16'({busy, mode_status}), 16'd3);
        tick_32k = 1; step(1); tick_32k = 0;
        chk("R11 start on tick", 16'(busy), 1);
        step(3);
        chk("R11 done", 16'({busy, mode_status}), 16'd0);
        cur_m = 0;

        // R12: wake from SLEEP (tick held high)
        tick_32k = 1;
        go(3, "R12 setup");
        wake_irq = 1; step(1); wake_irq = 0;
        step(4);
        chk("R12 wake from SLEEP", 16'({busy, mode_status}), 16'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule